// File: doc/BRIEF.md
# IEBus Slave-Transmit Frame Sequencer

This block follows one bus frame, bit by bit, while the local unit is the slave that answers a master's read. A bit-level line interface supplies a strobe for each bit slot (`bit_stb`) and the value the bus settled to in that slot (`rx_bit`). The sequencer tracks which field and bit the frame is in, checks the parity of the fields the master sends, and drives the acknowledge bits it owes. It then sends the telegraph-length field and the data bytes, each with its parity bit.

Before a frame, software programs the unit address and the byte count, preloads the first data byte into the data register and sets the enable. Each later byte is fetched by a one-cycle refill request, which a DMA engine answers with a register write. Two status pulses tell software that a qualifying control code arrived and that the frame is over, either completed or aborted.

Top module: `iebst_top`

## Requirements
- R1: After reset `tx_en`=0, `tx_bit`=1, `busy`=0, `err_par`=0, and `dreq`, `irq_ctrl`, `irq_end` are all 0. While idle the block never drives the bus.
- R2: With `cfg_en`=1, a `start_det` pulse starts a frame. Slots then run in this order: broadcast bit, 12-bit master address, 12-bit slave address, 4-bit control, 8-bit length, then 8-bit data bytes. All fields are sent MSB first. Each field is followed by an even-parity bit, which is the XOR of the field's bits.
- R3: The slave-address field is acknowledged only when the received address equals `cfg_unit_addr`, or when the broadcast bit was 0 (0 means broadcast). On a mismatch the block returns to idle with no acknowledge and no interrupt.
- R4: A parity mismatch on the master address, slave address or control field sets `err_par`, pulses `irq_end`, returns the block to idle and gives no acknowledge.
- R5: The control field is always acknowledged. `irq_ctrl` pulses for one cycle after its acknowledge slot only when the control code is 0, 4, 5 or 6.
- R6: The block sends the length field from `cfg_len` (latched at start), followed by its parity bit. In the acknowledge slot after it, the master drives 0 to acknowledge; a 1 makes the block resend the length field.
- R7: The first data byte is the value preloaded into the data register. When each data byte starts, `dreq` pulses once unless that byte is the last, so a frame of n bytes issues n-1 requests.
- R8: A data byte whose acknowledge slot reads 1 is resent unchanged. It is not counted and raises no new `dreq`.
- R9: A `cfg_len` of 0 means 256 data bytes.
- R10: After the acknowledge of byte n, `irq_end` pulses once and `busy` falls.
- R11: An acknowledge the block owes is given by driving 0 with `tx_en`=1 in the slot after the parity bit.
- R12: With `cfg_en`=0, `start_det` is ignored: `busy` stays 0 and no acknowledge is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_en | input | 1 | Communication enable |
| cfg_unit_addr | input | 12 | Own unit address |
| cfg_len | input | 8 | Data byte count (0 = 256) |
| dr_wr | input | 1 | Data register write strobe |
| dr_wdata | input | 8 | Data register write value |
| start_det | input | 1 | Start condition seen on the bus |
| bit_stb | input | 1 | End of a bit slot; `rx_bit` is valid |
| rx_bit | input | 1 | Bus value of the current slot |
| tx_en | output | 1 | Block drives the bus in this slot |
| tx_bit | output | 1 | Value driven when `tx_en`=1 |
| dreq | output | 1 | Data register refill request pulse |
| irq_ctrl | output | 1 | Qualifying control code pulse |
| irq_end | output | 1 | Frame end or abort pulse |
| err_par | output | 1 | Parity error of the last frame |
| busy | output | 1 | Frame in progress |

## Verification
A bus model sets each slot to the AND of the master's bit and the block's driven bit. Every data byte the block sends is compared with a computed pattern, so any slip in bit order or byte fetch shows up. Three sweeps exercise the main paths:
- All 16 control codes, which separates the interrupt-gated codes from the rest.
- Byte counts 1 to 9 and 0, which separates the refill count n-1 from n and the 256-byte wrap.
- Corrupted parity in each received field, a mismatched address with and without broadcast, and a single negative acknowledge on the length field and on a data byte, which separate abort, silent drop and retransmit.

// File: rtl/iebst_pkg.sv
package iebst_pkg;
    // Frame position of the sequencer
    typedef enum logic [2:0] {
        ST_IDLE, ST_BCAST, ST_MADDR, ST_SADDR, ST_CTRL, ST_LEN, ST_DATA
    } iebst_state_e;
endpackage

// File: rtl/iebst_par_acc.sv
// Running XOR of the received field bits.
// Assumes: clr and en are never high together when the result matters;
// clr wins.
module iebst_par_acc (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    input  logic din,
    output logic odd
);
    // accumulate one received bit, or restart for the next field
    always_ff @(posedge clk) begin
        if (!rst_n)      odd <= 1'b0;
        else if (clr)    odd <= 1'b0;
        else if (en)     odd <= odd ^ din;
    end
endmodule

// File: rtl/iebst_tx_store.sv
// Data register, current transmit byte and remaining-byte count.
// Issues the refill request each time a non-final byte is taken.
// Assumes: advance is only raised while cnt is non-zero.
module iebst_tx_store #(
    parameter  int DATA_W = 8,
    localparam int CNT_W  = DATA_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              load_first,
    input  logic [CNT_W-1:0]  len_val,
    input  logic              advance,
    output logic [DATA_W-1:0] cur,
    output logic              last,
    output logic              dreq
);
    logic [DATA_W-1:0] dr;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  cnt_dec;

    assign cnt_dec = cnt - CNT_W'(1);
    assign last    = (cnt == CNT_W'(1));

    // register writes, byte hand-over to the shifter and refill request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dr   <= '0;
            cur  <= '0;
            cnt  <= '0;
            dreq <= 1'b0;
        end else begin
            dreq <= 1'b0;
            if (wr) dr <= wdata;
            if (load_first) begin
                cur  <= dr;
                cnt  <= len_val;
                dreq <= (len_val > CNT_W'(1));
            end else if (advance) begin
                cnt <= cnt_dec;
                if (cnt_dec != '0) begin
                    cur  <= dr;
                    dreq <= (cnt_dec > CNT_W'(1));
                end
            end
        end
    end

    // a refill is only asked for while more bytes must follow
    p_dreq_more_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dreq |-> (cnt > CNT_W'(1)));
    // the count never grows except at a frame's first byte (nack keeps it)
    p_cnt_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !load_first |=> (cnt <= $past(cnt)));
endmodule

// File: rtl/iebst_top.sv
// Slave-transmit frame sequencer. It follows the frame slot by slot on
// bit_stb, checks received parity, gives the acknowledges it owes, and
// sends the length and data fields.
// Assumes: one bit_stb per slot, rx_bit is valid with it, and a frame
// never starts while busy.
module iebst_top #(
    parameter int               ADDR_W    = 12,
    parameter int               CTRL_W    = 4,
    parameter int               DATA_W    = 8,
    parameter logic [(1<<4)-1:0] IRQ_CODES = 16'h0071
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_en,
    input  logic [ADDR_W-1:0] cfg_unit_addr,
    input  logic [DATA_W-1:0] cfg_len,
    input  logic              dr_wr,
    input  logic [DATA_W-1:0] dr_wdata,
    input  logic              start_det,
    input  logic              bit_stb,
    input  logic              rx_bit,
    output logic              tx_en,
    output logic              tx_bit,
    output logic              dreq,
    output logic              irq_ctrl,
    output logic              irq_end,
    output logic              err_par,
    output logic              busy
);
    import iebst_pkg::*;

    localparam int MAXF  = ((ADDR_W > DATA_W) ? ADDR_W : DATA_W) + 2;
    localparam int IDX_W = $clog2(MAXF + 1);
    localparam int CNT_W = DATA_W + 1;

    iebst_state_e      state;
    logic [IDX_W-1:0]  idx;
    logic [IDX_W-1:0]  field_w;
    logic              bcast;
    logic [ADDR_W-1:0] sa_sh;
    logic [CTRL_W-1:0] ctl_sh;
    logic [DATA_W-1:0] len_q;
    logic [DATA_W-1:0] cur;
    logic [DATA_W-1:0] src_sh;
    logic [CNT_W-1:0]  len_val;
    logic              is_data, is_par, is_ack;
    logic              pa_odd, par_ok, addr_hit, last;
    logic              ld_first, advance;

    // field width of the current state
    always_comb begin
        case (state)
            ST_MADDR, ST_SADDR: field_w = IDX_W'(ADDR_W);
            ST_CTRL:            field_w = IDX_W'(CTRL_W);
            default:            field_w = IDX_W'(DATA_W);
        endcase
    end

    assign is_data  = (idx < field_w);
    assign is_par   = (idx == field_w);
    assign is_ack   = (idx == field_w + IDX_W'(1));
    assign par_ok   = (pa_odd == rx_bit);
    assign addr_hit = bcast || (sa_sh == cfg_unit_addr);
    assign len_val  = (len_q == '0) ? {1'b1, {DATA_W{1'b0}}} : {1'b0, len_q};
    assign ld_first = bit_stb && (state == ST_LEN)  && is_ack && !rx_bit;
    assign advance  = bit_stb && (state == ST_DATA) && is_ack && !rx_bit;
    assign busy     = (state != ST_IDLE);

    iebst_par_acc u_par (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (bit_stb && !is_data),
        .en    (bit_stb && is_data &&
                (state == ST_MADDR || state == ST_SADDR || state == ST_CTRL)),
        .din   (rx_bit),
        .odd   (pa_odd)
    );

    iebst_tx_store #(.DATA_W(DATA_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr         (dr_wr),
        .wdata      (dr_wdata),
        .load_first (ld_first),
        .len_val    (len_val),
        .advance    (advance),
        .cur        (cur),
        .last       (last),
        .dreq       (dreq)
    );

    // bus drive for the current slot: owed acknowledges, then length and data
    always_comb begin
        src_sh = ((state == ST_LEN) ? len_q : cur) << idx;
        tx_en  = 1'b0;
        tx_bit = 1'b1;
        if ((state == ST_SADDR || state == ST_CTRL) && is_ack) begin
            tx_en  = 1'b1;
            tx_bit = 1'b0;
        end else if ((state == ST_LEN || state == ST_DATA) && (is_data || is_par)) begin
            tx_en  = 1'b1;
            tx_bit = is_data ? src_sh[DATA_W-1]
                             : ^((state == ST_LEN) ? len_q : cur);
        end
    end

    // frame sequencing: one step per bit strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            idx      <= '0;
            bcast    <= 1'b0;
            sa_sh    <= '0;
            ctl_sh   <= '0;
            len_q    <= '0;
            err_par  <= 1'b0;
            irq_ctrl <= 1'b0;
            irq_end  <= 1'b0;
        end else begin
            irq_ctrl <= 1'b0;
            irq_end  <= 1'b0;
            if (state == ST_IDLE) begin
                if (cfg_en && start_det) begin
                    state   <= ST_BCAST;
                    idx     <= '0;
                    err_par <= 1'b0;
                    len_q   <= cfg_len;
                end
            end else if (bit_stb) begin
                idx <= idx + IDX_W'(1);
                case (state)
                    ST_BCAST: begin
                        bcast <= !rx_bit;
                        state <= ST_MADDR;
                        idx   <= '0;
                    end
                    ST_MADDR: if (is_par) begin
                        idx <= '0;
                        if (!par_ok) begin
                            err_par <= 1'b1; irq_end <= 1'b1; state <= ST_IDLE;
                        end else state <= ST_SADDR;
                    end
                    ST_SADDR: begin
                        if (is_data) sa_sh <= {sa_sh[ADDR_W-2:0], rx_bit};
                        if (is_par && !par_ok) begin
                            err_par <= 1'b1; irq_end <= 1'b1; state <= ST_IDLE;
                        end else if (is_par && !addr_hit) begin
                            state <= ST_IDLE;
                        end else if (is_ack) begin
                            state <= ST_CTRL;
                            idx   <= '0;
                        end
                    end
                    ST_CTRL: begin
                        if (is_data) ctl_sh <= {ctl_sh[CTRL_W-2:0], rx_bit};
                        if (is_par && !par_ok) begin
                            err_par <= 1'b1; irq_end <= 1'b1; state <= ST_IDLE;
                        end else if (is_ack) begin
                            irq_ctrl <= IRQ_CODES[ctl_sh];
                            state    <= ST_LEN;
                            idx      <= '0;
                        end
                    end
                    ST_LEN: if (is_ack) begin
                        idx <= '0;
                        if (!rx_bit) state <= ST_DATA;
                    end
                    ST_DATA: if (is_ack) begin
                        idx <= '0;
                        if (!rx_bit && last) begin
                            state   <= ST_IDLE;
                            irq_end <= 1'b1;
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    // never drive the bus outside a frame
    p_idle_silent_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !tx_en);
    // a new parity error always comes with the end pulse and idle
    p_perr_ends_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_par) |-> (irq_end && state == ST_IDLE));
    // the control interrupt only follows the control acknowledge
    p_ctrl_irq_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ctrl |-> (state == ST_LEN && idx == '0));
    // the end pulse leaves the block idle
    p_end_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_end |-> !busy);
    // a refill request is only raised inside the data phase
    p_dreq_in_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dreq |-> (state == ST_DATA));
endmodule

// File: tb/iebst_top_test.sv
module iebst_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_en = 1'b1;
    logic [11:0] cfg_unit_addr = 12'h5A3;
    logic [7:0]  cfg_len = 8'd1;
    logic        dr_wr = 1'b0;
    logic [7:0]  dr_wdata = 8'd0;
    logic        start_det = 1'b0;
    logic        bit_stb = 1'b0;
    logic        rx_bit = 1'b1;
    logic        tx_en, tx_bit, dreq, irq_ctrl, irq_end, err_par, busy;

    int n_chk = 0, n_bad = 0;
    int c_dreq = 0, c_ictl = 0, c_iend = 0;
    int dma_idx = 0;
    bit dma_on = 1'b0;

    always #2 clk = ~clk;

    iebst_top uut (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_unit_addr(cfg_unit_addr),
        .cfg_len(cfg_len), .dr_wr(dr_wr), .dr_wdata(dr_wdata),
        .start_det(start_det), .bit_stb(bit_stb), .rx_bit(rx_bit),
        .tx_en(tx_en), .tx_bit(tx_bit), .dreq(dreq), .irq_ctrl(irq_ctrl),
        .irq_end(irq_end), .err_par(err_par), .busy(busy)
    );

    function automatic logic [7:0] pat(input int j);
        return 8'(j * 37 + 5);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // pulse counters, sampled away from the active edge
    initial forever begin
        @(negedge clk);
        if (dreq)     c_dreq++;
        if (irq_ctrl) c_ictl++;
        if (irq_end)  c_iend++;
    end

    // DMA model: answers each refill request with the next pattern byte
    initial forever begin
        @(negedge clk);
        if (dma_on && dreq) begin
            dr_wdata = pat(dma_idx);
            dr_wr    = 1'b1;
            dma_idx++;
            @(negedge clk);
            dr_wr = 1'b0;
        end
    end

    // one bit slot: bus = master bit AND slave drive
    task automatic slot(input bit mb, output bit bus);
        @(negedge clk);
        bus     = mb & (tx_en ? tx_bit : 1'b1);
        rx_bit  = bus;
        bit_stb = 1'b1;
        @(negedge clk);
        bit_stb = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic preload();
        @(negedge clk);
        dma_idx  = 1;
        dr_wdata = pat(0);
        dr_wr    = 1'b1;
        @(negedge clk);
        dr_wr    = 1'b0;
        dma_on   = 1'b1;
    endtask

    // master side of a whole frame; badf 1/2/3 corrupts that field's parity
    task automatic frame(input bit bc, input logic [11:0] ma, input logic [11:0] sa,
                         input logic [3:0] ctl, input logic [7:0] ln, input int badf,
                         input bit lnack, input int nack_at,
                         output bit sa_ack, output int errs, output int sent,
                         output int lsent);
        bit b, p, pend, nacked;
        logic [7:0] rb;
        int n, k;
        sa_ack = 0; errs = 0; sent = 0; lsent = 0;
        cfg_len = ln;
        preload();
        @(negedge clk); start_det = 1'b1;
        @(negedge clk); start_det = 1'b0;
        slot(~bc, b);
        for (int i = 11; i >= 0; i--) slot(ma[i], b);
        slot((^ma) ^ (badf == 1), b);
        if (badf == 1) begin repeat (3) @(negedge clk); return; end
        for (int i = 11; i >= 0; i--) slot(sa[i], b);
        slot((^sa) ^ (badf == 2), b);
        slot(1'b1, b);
        sa_ack = !b;
        if (!sa_ack) begin repeat (3) @(negedge clk); return; end
        for (int i = 3; i >= 0; i--) slot(ctl[i], b);
        slot((^ctl) ^ (badf == 3), b);
        slot(1'b1, b);
        if (badf == 3) begin repeat (3) @(negedge clk); return; end
        pend = lnack;
        do begin
            for (int i = 0; i < 8; i++) begin slot(1'b1, b); rb = {rb[6:0], b}; end
            slot(1'b1, p);
            lsent++;
            if (rb !== ln || p != ^ln) errs++;
            slot(pend, b);
            b = pend; pend = 0;
        end while (b);
        n = (ln == 0) ? 256 : int'(ln);
        k = 0; nacked = 0;
        while (k < n) begin
            for (int i = 0; i < 8; i++) begin slot(1'b1, b); rb = {rb[6:0], b}; end
            slot(1'b1, p);
            sent++;
            if (rb !== pat(k) || p != ^rb) errs++;
            if (k == nack_at && !nacked) begin nacked = 1; slot(1'b1, b); end
            else begin slot(1'b0, b); k++; end
        end
        repeat (3) @(negedge clk);
    endtask

    // watchdog
    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        bit a; int e, s, l, d0, i0, c0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!tx_en && tx_bit && !busy && !err_par, "R1 reset drive", {tx_en, tx_bit, busy, err_par}, 4'b0100);
        chk(!dreq && !irq_ctrl && !irq_end, "R1 reset pulses", {dreq, irq_ctrl, irq_end}, 0);

        // R2 R3 R6 R7 R10 ordinary frame of 3 bytes
        d0 = c_dreq; i0 = c_iend; c0 = c_ictl;
        frame(0, 12'h1C4, 12'h5A3, 4'h3, 8'd3, 0, 0, -1, a, e, s, l);
        chk(a, "R3 own address ack", a, 1);
        chk(e == 0, "R2 R6 field bits and parity", e, 0);
        chk(s == 3, "R7 bytes sent", s, 3);
        chk(c_dreq - d0 == 2, "R7 refill count", c_dreq - d0, 2);
        chk(c_iend - i0 == 1 && !busy, "R10 end pulse", c_iend - i0, 1);
        chk(c_ictl - c0 == 0, "R5 code 3 silent", c_ictl - c0, 0);

        // R5 control code sweep
        for (int c = 0; c < 16; c++) begin
            c0 = c_ictl; d0 = c_dreq;
            frame(0, 12'h0F0, 12'h5A3, 4'(c), 8'd1, 0, 0, -1, a, e, s, l);
            chk(c_ictl - c0 == ((c == 0 || c == 4 || c == 5 || c == 6) ? 1 : 0),
                "R5 control irq gating", c_ictl - c0, (c == 0 || c == 4 || c == 5 || c == 6) ? 1 : 0);
            chk(c_dreq - d0 == 0 && e == 0, "R7 single byte no refill", c_dreq - d0, 0);
        end

        // R7 R10 length sweep
        for (int n = 1; n <= 9; n++) begin
            d0 = c_dreq; i0 = c_iend;
            frame(0, 12'hABC, 12'h5A3, 4'h7, 8'(n), 0, 0, -1, a, e, s, l);
            chk(c_dreq - d0 == n - 1, "R7 refills per length", c_dreq - d0, n - 1);
            chk(e == 0 && s == n, "R7 data bytes", s, n);
            chk(c_iend - i0 == 1, "R10 end per frame", c_iend - i0, 1);
        end

        // R3 mismatch, no broadcast
        i0 = c_iend;
        frame(0, 12'h111, 12'h5A2, 4'h3, 8'd2, 0, 0, -1, a, e, s, l);
        chk(!a, "R3 mismatch no ack", a, 0);
        chk(!busy && c_iend - i0 == 0, "R3 mismatch silent", c_iend - i0, 0);

        // R3 R11 broadcast with foreign address
        frame(1, 12'h222, 12'h0FF, 4'h3, 8'd2, 0, 0, -1, a, e, s, l);
        chk(a && e == 0 && s == 2, "R3 R11 broadcast ack", a, 1);

        // R4 parity errors on each received field
        for (int f = 1; f <= 3; f++) begin
            i0 = c_iend; c0 = c_ictl;
            frame(0, 12'h333, 12'h5A3, 4'h0, 8'd2, f, 0, -1, a, e, s, l);
            chk(err_par && !busy, "R4 parity abort", err_par, 1);
            chk(c_iend - i0 == 1, "R4 abort end pulse", c_iend - i0, 1);
            chk(c_ictl - c0 == 0, "R4 no control irq", c_ictl - c0, 0);
            if (f == 2) chk(!a, "R4 no ack on bad parity", a, 0);
        end

        // R6 length nack, R8 data nack
        d0 = c_dreq;
        frame(0, 12'h444, 12'h5A3, 4'h3, 8'd4, 0, 1, 1, a, e, s, l);
        chk(err_par == 0 && e == 0, "R8 retransmitted content", e, 0);
        chk(l == 2, "R6 length resent", l, 2);
        chk(s == 5, "R8 byte resent once", s, 5);
        chk(c_dreq - d0 == 3, "R8 no extra refill", c_dreq - d0, 3);

        // R9 length zero means 256
        d0 = c_dreq;
        frame(0, 12'h555, 12'h5A3, 4'h3, 8'd0, 0, 0, -1, a, e, s, l);
        chk(s == 256 && e == 0, "R9 256 bytes", s, 256);
        chk(c_dreq - d0 == 255, "R9 refills", c_dreq - d0, 255);

        // R12 disabled block ignores start
        cfg_en = 1'b0;
        frame(0, 12'h666, 12'h5A3, 4'h3, 8'd1, 0, 0, -1, a, e, s, l);
        chk(!a && !busy, "R12 disabled ignore", a, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule